// File: doc/BRIEF.md
# Multichannel DAC Load Sequencer

This block controls how the output registers of a sixteen-channel converter are refreshed from their computed holding values. A single calculation engine is shared by all channels, so a data write that touches several channels is worked through one channel at a time. The busy indication stays active for the whole pass. The arithmetic is replaced here by a stub that takes one fixed slot per channel. When a channel's slot ends, the block marks that channel as changed.

A load request comes from an active-low strobe. It is carried out only when the local engine is idle and the shared open-drain busy line reads high. This lets several devices on that line update together. A request made while busy is remembered. Only channels whose holding value changed since the previous load get a load enable. An active-low clear input blocks loads and selects the ground-reference output path. The changed-channel record is kept through a clear.

Timing comes from the parameter `CLK_NS`. A slot is 600 ns and the closing tail is 300 ns. With the defaults this is 6 cycles and 3 cycles.

Top module: `dacLoadSeq`

## Requirements
- R1: While reset is active and on the first cycle after it, `busyN` is 1, `outLoad` is all zero and `clearSel` is 0.
- R2: A data write (`wrValid`=1, `wrSelect`=0) with N bits set in `wrMask` (bit i is channel i) while idle drives `busyN` low from the next cycle for exactly (N+1)·SLOT+TAIL cycles. SLOT = 600/`CLK_NS` and TAIL = 300/`CLK_NS`.
- R3: A select write (`wrValid`=1, `wrSelect`=1) while idle drives `busyN` low for exactly SLOT cycles and marks no channel as changed.
- R4: A data write during an active pass, made before its tail, adds its new channels to the pass and lengthens the busy time by SLOT cycles per added channel.
- R5: A falling edge of `loadN` seen while busy is stored. The load is performed in the cycle after `busyN` returns high, provided `busyExtIn` is high.
- R6: With `loadN` held low, a load is performed after every pass ends, without any new falling edge.
- R7: A load drives `outLoad` for exactly one cycle, with a bit set only for the channels computed since the previous load.
- R8: While `clrN` is low, `clearSel` is 1 one cycle later, load strobes are ignored and a stored request is discarded. The changed-channel record is kept, so a later load still updates those channels.
- R9: While `busyExtIn` is low, a stored load waits. It fires in the cycle after `busyExtIn` rises.
- R10: Data writes are accepted while busy and keep `busyN` low. `outLoad` stays zero in any cycle that follows a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write strobe, one cycle |
| wrSelect | input | 1 | 1: A/B select write, 0: data write |
| wrMask | input | NUM_CH | Channels touched by a data write |
| loadN | input | 1 | Active-low load strobe |
| clrN | input | 1 | Active-low clear |
| busyExtIn | input | 1 | Level of the shared open-drain busy line |
| busyN | output | 1 | Active-low local busy drive |
| outLoad | output | NUM_CH | Per-channel output register load enables |
| clearSel | output | 1 | Selects the ground-reference output path |

## Verification
The assertions assume that `clrN` is high while reset is released. They also assume that every input is synchronous to `clk` and changes only between edges. The bench holds `clrN` high through reset and drives all inputs on the falling clock edge. The reference model predicts busy length by counting channels new to a pass. For that reason the stimulus adds channels to a pass only before its tail, only with channels not yet in it, and never starts a data write during a select pass.

// File: rtl/dlsPkg.sv
package dlsPkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CALC,
    PH_TAIL,
    PH_SEL
  } phase_e;

  localparam int CHAN_IDX_W = 8;

  typedef struct packed {
    logic                  calcDone;
    logic [CHAN_IDX_W-1:0] calcChan;
    logic                  loadFire;
  } strobe_t;
endpackage

// File: rtl/dlsPick.sv
module dlsPick #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0]             req,
  output logic [dlsPkg::CHAN_IDX_W-1:0] idx,
  output logic                          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = dlsPkg::CHAN_IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dlsCtrl.sv
module dlsCtrl
  import dlsPkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SLOT_CYC = 6,
  parameter int TAIL_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrSelect,
  input  logic [NUM_CH-1:0] wrMask,
  input  logic              loadN,
  input  logic              clrN,
  input  logic              busyExtIn,
  output logic              busyN,
  output strobe_t           strobe
);
  localparam int MAX_CYC = (SLOT_CYC > TAIL_CYC) ? SLOT_CYC : TAIL_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  phase_e                  phase, phaseNext;
  logic [CW-1:0]           cnt, cntNext;
  logic [NUM_CH-1:0]       queue, queueAfter, wrMaskEff;
  logic [CHAN_IDX_W-1:0]   cur, curNext, pickIdx;
  logic                    pickAny;
  logic                    loadPend, loadPrev, fire, busyInt, slotEnd;
  logic                    wrData, wrSel;

  assign wrData    = wrValid && !wrSelect && (|wrMask);
  assign wrSel     = wrValid && wrSelect;
  assign wrMaskEff = wrData ? wrMask : '0;
  assign slotEnd   = (cnt == '0);
  assign busyInt   = (phase != PH_IDLE);
  assign busyN     = !busyInt;

  always_comb begin
    queueAfter = queue | wrMaskEff;
    if (phase == PH_CALC && slotEnd)
      queueAfter = (queue & ~(NUM_CH'(1) << cur)) | wrMaskEff;
  end

  dlsPick #(.NUM_CH(NUM_CH)) i_pick (
    .req (queueAfter),
    .idx (pickIdx),
    .any (pickAny)
  );

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    curNext   = cur;
    case (phase)
      PH_IDLE: begin
        if (wrData) begin
          phaseNext = PH_SETUP;
          cntNext   = CW'(SLOT_CYC - 1);
        end else if (wrSel) begin
          phaseNext = PH_SEL;
          cntNext   = CW'(SLOT_CYC - 1);
        end
      end
      PH_SETUP: begin
        if (slotEnd) begin
          phaseNext = PH_CALC;
          cntNext   = CW'(SLOT_CYC - 1);
          curNext   = pickIdx;
        end else cntNext = cnt - 1'b1;
      end
      PH_CALC, PH_TAIL: begin
        if (slotEnd) begin
          if (pickAny) begin
            phaseNext = PH_CALC;
            cntNext   = CW'(SLOT_CYC - 1);
            curNext   = pickIdx;
          end else if (phase == PH_CALC) begin
            phaseNext = PH_TAIL;
            cntNext   = CW'(TAIL_CYC - 1);
          end else phaseNext = PH_IDLE;
        end else cntNext = cnt - 1'b1;
      end
      PH_SEL: begin
        if (slotEnd) begin
          if (pickAny) begin
            phaseNext = PH_SETUP;
            cntNext   = CW'(SLOT_CYC - 1);
          end else phaseNext = PH_IDLE;
        end else cntNext = cnt - 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  // Load request: stored on a falling edge, or taken from a held-low level.
  assign fire = clrN && !busyInt && busyExtIn && (loadPend || !loadN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      queue    <= '0;
      cur      <= '0;
      loadPend <= 1'b0;
      loadPrev <= 1'b1;
    end else begin
      phase    <= phaseNext;
      cnt      <= cntNext;
      queue    <= queueAfter;
      cur      <= curNext;
      loadPrev <= loadN;
      if (!clrN || fire) loadPend <= 1'b0;
      else if (loadPrev && !loadN) loadPend <= 1'b1;
    end
  end

  assign strobe.calcDone = (phase == PH_CALC) && slotEnd;
  assign strobe.calcChan = cur;
  assign strobe.loadFire = fire;
endmodule

// File: rtl/dlsData.sv
module dlsData
  import dlsPkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              clrN,
  output logic [NUM_CH-1:0] outLoad,
  output logic              clearSel
);
  logic [NUM_CH-1:0] dirty, doneMask;

  assign doneMask = strobe.calcDone ? (NUM_CH'(1) << strobe.calcChan) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty    <= '0;
      outLoad  <= '0;
      clearSel <= 1'b0;
    end else begin
      dirty    <= (strobe.loadFire ? '0 : dirty) | doneMask;
      outLoad  <= strobe.loadFire ? dirty : '0;
      clearSel <= !clrN;
    end
  end
endmodule

// File: rtl/dacLoadSeq.sv
module dacLoadSeq
  import dlsPkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int CLK_NS  = 100,
  parameter int SLOT_NS = 600,
  parameter int TAIL_NS = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrSelect,
  input  logic [NUM_CH-1:0] wrMask,
  input  logic              loadN,
  input  logic              clrN,
  input  logic              busyExtIn,
  output logic              busyN,
  output logic [NUM_CH-1:0] outLoad,
  output logic              clearSel
);
  localparam int SLOT_CYC = SLOT_NS / CLK_NS;
  localparam int TAIL_CYC = TAIL_NS / CLK_NS;

  strobe_t strobe;

  dlsCtrl #(.NUM_CH(NUM_CH), .SLOT_CYC(SLOT_CYC), .TAIL_CYC(TAIL_CYC)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .wrSelect  (wrSelect),
    .wrMask    (wrMask),
    .loadN     (loadN),
    .clrN      (clrN),
    .busyExtIn (busyExtIn),
    .busyN     (busyN),
    .strobe    (strobe)
  );

  dlsData #(.NUM_CH(NUM_CH)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .clrN     (clrN),
    .outLoad  (outLoad),
    .clearSel (clearSel)
  );
endmodule

// File: rtl/dlsCheck.sv
module dlsCheck #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              wrSelect,
  input logic [NUM_CH-1:0] wrMask,
  input logic              loadN,
  input logic              clrN,
  input logic              busyExtIn,
  input logic              busyN,
  input logic [NUM_CH-1:0] outLoad,
  input logic              clearSel
);
  assert_busy_on_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrSelect && (|wrMask) && busyN) |=> !busyN);

  assert_busy_on_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSelect && busyN) |=> !busyN);

  assert_load_needs_free_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|outLoad) |-> ($past(busyN) && $past(busyExtIn)));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|outLoad) |=> ((outLoad & $past(outLoad)) == '0));

  assert_no_load_in_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrN) |-> (outLoad == '0));

  assert_clear_select_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearSel == !$past(clrN));

  assert_write_keeps_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrSelect && (|wrMask) && !busyN) |=> !busyN);
endmodule

bind dacLoadSeq dlsCheck #(.NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_dacLoadSeq.sv
module test_dacLoadSeq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 16;
  localparam int SLOT = 6;
  localparam int TAIL = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0, wrSelect = 1'b0, loadN = 1'b1, clrN = 1'b1, busyExtIn = 1'b1;
  logic [NCH-1:0] wrMask = '0;
  logic busyN, clearSel;
  logic [NCH-1:0] outLoad;

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";

  // reference model state
  int mBusyLeft = 0;
  logic [NCH-1:0] mDirty = '0, mPassSet = '0, mLoad = '0, seenLoad = '0;
  logic mPend = 1'b0, mPrevLoadN = 1'b1, mClear = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacLoadSeq #(.NUM_CH(NCH), .CLK_NS(100)) i_dacLoadSeq (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSelect(wrSelect), .wrMask(wrMask),
    .loadN(loadN), .clrN(clrN), .busyExtIn(busyExtIn),
    .busyN(busyN), .outLoad(outLoad), .clearSel(clearSel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBusyLeft = 0; mDirty = '0; mPassSet = '0; mLoad = '0;
      mPend = 1'b0; mPrevLoadN = 1'b1; mClear = 1'b0;
    end else begin
      bit fireNow;
      fireNow = clrN && (mBusyLeft == 0) && busyExtIn && (mPend || !loadN);
      mLoad = fireNow ? mDirty : '0;
      if (fireNow) mDirty = '0;
      if (!clrN || fireNow) mPend = 1'b0;
      else if (mPrevLoadN && !loadN) mPend = 1'b1;
      mPrevLoadN = loadN;
      mClear = !clrN;
      if (wrValid && !wrSelect && wrMask != '0) begin
        mDirty |= wrMask;
        if (mBusyLeft == 0) begin
          mBusyLeft = ($countones(wrMask) + 1) * SLOT + TAIL;
          mPassSet = wrMask;
        end else begin
          mBusyLeft = mBusyLeft - 1 + $countones(wrMask & ~mPassSet) * SLOT;
          mPassSet |= wrMask;
        end
      end else if (wrValid && wrSelect && mBusyLeft == 0) begin
        mBusyLeft = SLOT;
      end else if (mBusyLeft > 0) begin
        mBusyLeft--;
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      check(busyN == (mBusyLeft == 0), curReq, "busyN", 32'(busyN), 32'(mBusyLeft == 0));
      check(outLoad == mLoad, curReq, "outLoad", 32'(outLoad), 32'(mLoad));
      check(clearSel == mClear, curReq, "clearSel", 32'(clearSel), 32'(mClear));
      seenLoad |= outLoad;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [NCH-1:0] m, input logic sel);
    wrValid = 1'b1; wrSelect = sel; wrMask = m;
    @(negedge clk);
    wrValid = 1'b0; wrSelect = 1'b0; wrMask = '0;
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; @(negedge clk); loadN = 1'b1;
  endtask

  task automatic waitIdle();
    while (!busyN) @(negedge clk);
    tick(2);
  endtask

  task automatic measureBusy(input string req, input int expLen);
    int len = 0;
    while (!busyN) begin len++; @(negedge clk); end
    check(len == expLen, req, "busy length", 32'(len), 32'(expLen));
  endtask

  initial begin
    // R1: reset state
    tick(3);
    check(busyN === 1'b1 && outLoad === '0 && clearSel === 1'b0, "R1", "reset outputs",
          {busyN, outLoad, clearSel}, {1'b1, 16'h0, 1'b0});
    rstN = 1'b1;
    tick(1);
    check(busyN === 1'b1 && outLoad === '0, "R1", "after reset", {busyN, outLoad}, {1'b1, 16'h0});

    // R2 and R7: one channel, then a load
    curReq = "R2";
    doWrite(16'h0008, 1'b0);
    measureBusy("R2", 2 * SLOT + TAIL);
    tick(2);
    curReq = "R7"; seenLoad = '0;
    pulseLoad(); tick(3);
    check(seenLoad == 16'h0008, "R7", "single channel load", 32'(seenLoad), 32'h0008);

    // R5: load strobe while busy, both groups same channel
    curReq = "R5"; seenLoad = '0;
    doWrite(16'h2020, 1'b0);
    tick(4); pulseLoad();
    check(seenLoad == '0, "R5", "no load while busy", 32'(seenLoad), 32'h0);
    waitIdle();
    check(seenLoad == 16'h2020, "R5", "stored load", 32'(seenLoad), 32'h2020);

    // R4, R6, R10: group write, appended write, load held low
    curReq = "R4"; seenLoad = '0;
    doWrite(16'h00FF, 1'b0);
    loadN = 1'b0;
    tick(10);
    curReq = "R10";
    doWrite(16'h0F00, 1'b0);
    check(busyN == 1'b0, "R10", "busy while appending", 32'(busyN), 32'h0);
    measureBusy("R4", (8 + 1 + 4) * SLOT + TAIL - 11);
    check(seenLoad == '0, "R10", "no load during pass", 32'(seenLoad), 32'h0);
    tick(2);
    check(seenLoad == 16'h0FFF, "R6", "held-low load", 32'(seenLoad), 32'h0FFF);
    curReq = "R6"; seenLoad = '0;
    doWrite(16'h0001, 1'b0);
    waitIdle();
    check(seenLoad == 16'h0001, "R6", "second held-low load", 32'(seenLoad), 32'h0001);
    loadN = 1'b1; tick(2);

    // R3: select write
    curReq = "R3"; seenLoad = '0;
    doWrite(16'h00F0, 1'b1);
    measureBusy("R3", SLOT);
    tick(2); pulseLoad(); tick(3);
    check(seenLoad == '0, "R3", "select marks nothing", 32'(seenLoad), 32'h0);

    // R9: external busy line held low
    curReq = "R9"; seenLoad = '0;
    busyExtIn = 1'b0;
    doWrite(16'h0004, 1'b0);
    pulseLoad();
    waitIdle(); tick(10);
    check(seenLoad == '0, "R9", "held by line", 32'(seenLoad), 32'h0);
    busyExtIn = 1'b1; tick(3);
    check(seenLoad == 16'h0004, "R9", "load after line release", 32'(seenLoad), 32'h0004);

    // R8: clear blocks loads and keeps the record
    curReq = "R8"; seenLoad = '0;
    doWrite(16'h0080, 1'b0);
    waitIdle();
    clrN = 1'b0; tick(2);
    check(clearSel == 1'b1, "R8", "clearSel high", 32'(clearSel), 32'h1);
    pulseLoad(); tick(3);
    check(seenLoad == '0, "R8", "load ignored in clear", 32'(seenLoad), 32'h0);
    clrN = 1'b1; tick(3);
    check(clearSel == 1'b0 && seenLoad == '0, "R8", "clear released, no load",
          {clearSel, seenLoad}, 32'h0);
    pulseLoad(); tick(3);
    check(seenLoad == 16'h0080, "R8", "record kept", 32'(seenLoad), 32'h0080);

    // R2: all channels
    curReq = "R2"; seenLoad = '0;
    doWrite(16'hFFFF, 1'b0);
    measureBusy("R2", 17 * SLOT + TAIL);
    tick(2); pulseLoad(); tick(3);
    check(seenLoad == 16'hFFFF, "R7", "all channels load", 32'(seenLoad), 32'hFFFF);

    tick(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule